// File: doc/BRIEF.md
# Dual Quad-SPI SRAM Controller

This controller connects a single-request host port to a pair of quad-SPI SRAM devices that share one 8-bit data bus. One device is wired to bus bits 3:0 and the other to bits 7:4. A single serial clock therefore moves one nibble into each device. As a result, a host byte is split across the two devices, and every transfer must give each device a whole number of its own bytes before chip select is released.

After reset the controller sends the enter-quad command once. It uses single-bit SPI on bus bits 0 and 4. After that it accepts read and write requests of 1, 2 or 4 bytes at a 24-bit byte address, and each request carries a size code. Data is little-endian in a 32-bit word. A single-byte access is padded with a second serial clock that repeats the same bus byte, so both devices see two nibbles. A request that would run past a 256 KB die boundary, or that carries an unknown size code, is refused without touching the bus.

The request port follows valid/ready rules. A request is taken on a clock where both `req_valid` and `req_ready` are high, and the host holds its fields stable until then. `req_ready` is low from the accept until chip select rises. Completion is a one-cycle `rsp_done` strobe. That strobe carries `rsp_err`, and `rsp_rdata` holds read data until the next accepted request. The response side has no back-pressure.

Top module: `dqspi_ctrl`

## Requirements
- R1: While reset is held: `spi_cs_n`=1, `spi_sclk`=0, `spi_oe`=0, `req_ready`=0, `rsp_done`=0.
- R2: After reset, the controller sends command 0x38 with chip select low, MSB first. It sends one bit per serial clock on bus bits 0 and 4 together, with all other bus bits 0, and `spi_oe`=1. After 8 serial clocks chip select goes high and `req_ready` goes high in the same cycle.
- R3: The serial clock runs at the system clock divided by 2. Each beat is one cycle with `spi_sclk` low followed by one cycle with it high. Chip select falls in the cycle after the accept, and that cycle is the low half of the first beat. `spi_sclk` is never high while chip select is high.
- R4: Every access starts with a header of 8 beats. The header is the command byte (0x02 for write, 0x03 for read) followed by the 24-bit address, sent as nibbles MSB first. The same nibble appears on bus bits 7:4 and 3:0.
- R5: Writes of 2 or 4 bytes follow the header with one beat per byte. The beats carry `req_wdata[7:0]` first and then each higher byte in turn.
- R6: A 1-byte write (size code 0) puts `req_wdata[7:0]` on the bus for two consecutive beats.
- R7: A read puts 2 turnaround beats after the header, with `spi_oe`=0. `spi_oe` stays 0 through the data beats. Input data is captured at the rising edge of the serial clock.
- R8: Read data is little-endian. The first data beat goes to bits 7:0, the next to 15:8, and so on. Unused upper bits read as 0. On a 1-byte read the second (pad) beat is ignored.
- R9: `req_ready` is low from the accept until chip select rises. `rsp_done` is high for exactly one cycle, the cycle in which chip select rises. `rsp_rdata` is valid from that cycle on.
- R10: A request with `addr[17:0]` + bytes > 0x40000 is refused. `rsp_done` and `rsp_err` pulse in the cycle after the accept, and chip select stays high.
- R11: Size codes are 0=1 byte, 1=2 bytes, 2=4 bytes. Size code 3 is refused in the same way as R10.
- R12: A new request can be accepted in the cycle where `rsp_done` is high. The size is captured at accept, so the host may keep the same size value across back-to-back requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low synchronous reset |
| req_valid | input | 1 | request present |
| req_ready | output | 1 | controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | size code: 0=1, 1=2, 2=4 bytes |
| req_addr | input | 24 | byte address |
| req_wdata | input | 32 | write data, little-endian |
| rsp_done | output | 1 | one-cycle completion strobe |
| rsp_err | output | 1 | request was refused (valid with rsp_done) |
| rsp_rdata | output | 32 | read data |
| spi_cs_n | output | 1 | chip select to both devices, active low |
| spi_sclk | output | 1 | serial clock to both devices |
| spi_oe | output | 1 | 1 = controller drives the shared bus |
| spi_dout | output | 8 | outgoing bus byte |
| spi_din | input | 8 | incoming bus byte |

## Verification
For an accepted access of B beats, chip select is low from the first cycle after the accept. Beat k occupies cycles 2k (clock low) and 2k+1 (clock high), and `rsp_done` with rising chip select is due in cycle 2B. A refused request shows its strobe in cycle 0, and the power-up command spans cycles 0 to 15 after reset release. The bench builds the expected bus byte, output enable and clock level for every beat from the request alone. It compares every output on every falling clock edge, and it drives each read byte during the low half of its beat, so it is stable before the capturing rising edge.

// File: rtl/dqspi_pkg.sv
package dqspi_pkg;

  typedef enum logic [1:0] {
    SEG_BOOT,
    SEG_HDR,
    SEG_TURN,
    SEG_DATA
  } seg_t;

  typedef enum logic [1:0] {
    ST_LAUNCH,
    ST_RUN,
    ST_IDLE
  } st_t;

  localparam logic [7:0] CMD_QUAD  = 8'h38;
  localparam logic [7:0] CMD_WRITE = 8'h02;
  localparam logic [7:0] CMD_READ  = 8'h03;

  localparam int HDR_BEATS  = 8;
  localparam int BOOT_BEATS = 8;

  function automatic logic [2:0] size_bytes(input logic [1:0] code);
    case (code)
      2'd0:    size_bytes = 3'd1;
      2'd1:    size_bytes = 3'd2;
      2'd2:    size_bytes = 3'd4;
      default: size_bytes = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/dqspi_req_check.sv
module dqspi_req_check #(
  parameter int ADDR_W   = 24,
  parameter int DIE_LOG2 = 18
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic              legal
);
  import dqspi_pkg::*;

  localparam logic [DIE_LOG2:0] DIE_BYTES = {1'b1, {DIE_LOG2{1'b0}}};

  logic [2:0]        nbytes;
  logic [DIE_LOG2:0] end_off;

  always_comb begin
    nbytes  = size_bytes(size);
    end_off = {1'b0, addr[DIE_LOG2-1:0]} + (DIE_LOG2+1)'(nbytes);
    legal   = (nbytes != 3'd0) && (end_off <= DIE_BYTES);
  end

endmodule

// File: rtl/dqspi_seq.sv
module dqspi_seq #(
  parameter int TURN_BEATS = 2,
  parameter int BEAT_W     = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic                  wr,
  input  logic [BEAT_W-1:0]     data_last,
  output logic                  cs_n,
  output logic                  sclk,
  output logic                  oe,
  output logic                  ready,
  output logic                  done,
  output dqspi_pkg::seg_t       seg,
  output logic [BEAT_W-1:0]     beat,
  output logic                  adv,
  output logic                  sample
);
  import dqspi_pkg::*;

  st_t               st;
  logic              hi;
  logic              wr_q;
  logic [BEAT_W-1:0] dlast_q;
  logic              seg_last;

  always_comb begin
    case (seg)
      SEG_BOOT: seg_last = (beat == BEAT_W'(BOOT_BEATS-1));
      SEG_HDR:  seg_last = (beat == BEAT_W'(HDR_BEATS-1));
      SEG_TURN: seg_last = (beat == BEAT_W'(TURN_BEATS-1));
      default:  seg_last = (beat == dlast_q);
    endcase
  end

  assign sclk   = hi;
  assign ready  = (st == ST_IDLE);
  assign adv    = (st == ST_RUN) && hi && !seg_last;
  assign sample = (st == ST_RUN) && !hi && (seg == SEG_DATA) && !wr_q;
  assign oe     = (st == ST_RUN) &&
                  ((seg == SEG_BOOT) || (seg == SEG_HDR) ||
                   ((seg == SEG_DATA) && wr_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_LAUNCH;
      cs_n    <= 1'b1;
      hi      <= 1'b0;
      seg     <= SEG_BOOT;
      beat    <= '0;
      done    <= 1'b0;
      wr_q    <= 1'b0;
      dlast_q <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_LAUNCH: begin
          st   <= ST_RUN;
          cs_n <= 1'b0;
          seg  <= SEG_BOOT;
          beat <= '0;
          hi   <= 1'b0;
        end
        ST_IDLE: begin
          if (start) begin
            st      <= ST_RUN;
            cs_n    <= 1'b0;
            seg     <= SEG_HDR;
            beat    <= '0;
            hi      <= 1'b0;
            wr_q    <= wr;
            dlast_q <= data_last;
          end
        end
        default: begin
          if (!hi) begin
            hi <= 1'b1;
          end else begin
            hi <= 1'b0;
            if (!seg_last) begin
              beat <= beat + 1'b1;
            end else begin
              beat <= '0;
              case (seg)
                SEG_BOOT: begin
                  st   <= ST_IDLE;
                  cs_n <= 1'b1;
                end
                SEG_HDR:  seg <= wr_q ? SEG_DATA : SEG_TURN;
                SEG_TURN: seg <= SEG_DATA;
                default: begin
                  st   <= ST_IDLE;
                  cs_n <= 1'b1;
                  done <= 1'b1;
                end
              endcase
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/dqspi_dpath.sv
module dqspi_dpath #(
  parameter int ADDR_W = 24,
  parameter int BEAT_W = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                wr,
  input  logic                single,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wdata,
  input  dqspi_pkg::seg_t     seg,
  input  logic [BEAT_W-1:0]   beat,
  input  logic                adv,
  input  logic                sample,
  input  logic [7:0]          din,
  output logic [7:0]          dout,
  output logic [31:0]         rdata
);
  import dqspi_pkg::*;

  logic [7:0]  boot_sr;
  logic [31:0] hdr_sr;
  logic [31:0] wr_sr;
  logic        single_q;
  logic [4:0]  lane_off;
  logic        take;

  assign lane_off = {beat[1:0], 3'b000};
  assign take     = sample && (!single_q || (beat == '0));

  always_comb begin
    case (seg)
      SEG_BOOT: dout = {3'b000, boot_sr[7], 3'b000, boot_sr[7]};
      SEG_HDR:  dout = {hdr_sr[31:28], hdr_sr[31:28]};
      SEG_DATA: dout = wr_sr[7:0];
      default:  dout = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_sr  <= CMD_QUAD;
      hdr_sr   <= '0;
      wr_sr    <= '0;
      single_q <= 1'b0;
      rdata    <= '0;
    end else if (start) begin
      hdr_sr   <= {wr ? CMD_WRITE : CMD_READ, 24'(addr)};
      wr_sr    <= wdata;
      single_q <= single;
      rdata    <= '0;
    end else begin
      if (adv) begin
        case (seg)
          SEG_BOOT: boot_sr <= {boot_sr[6:0], 1'b0};
          SEG_HDR:  hdr_sr  <= {hdr_sr[27:0], 4'h0};
          SEG_DATA: if (!single_q) wr_sr <= {8'h00, wr_sr[31:8]};
          default: ;
        endcase
      end
      if (take) rdata[lane_off +: 8] <= din;
    end
  end

endmodule

// File: rtl/dqspi_ctrl.sv
module dqspi_ctrl #(
  parameter int ADDR_W     = 24,
  parameter int DIE_LOG2   = 18,
  parameter int TURN_BEATS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_oe,
  output logic [7:0]        spi_dout,
  input  logic [7:0]        spi_din
);
  import dqspi_pkg::*;

  localparam int BEAT_W = (TURN_BEATS > 8) ? $clog2(TURN_BEATS) : 3;

  logic              legal;
  logic              accept;
  logic              start;
  logic              seq_done;
  logic              err_q;
  logic [BEAT_W-1:0] data_last;
  seg_t              seg;
  logic [BEAT_W-1:0] beat;
  logic              adv;
  logic              sample;

  assign accept    = req_valid && req_ready;
  assign start     = accept && legal;
  assign data_last = (req_size == 2'd2) ? BEAT_W'(3) : BEAT_W'(1);

  dqspi_req_check #(.ADDR_W(ADDR_W), .DIE_LOG2(DIE_LOG2)) i_check (
    .addr  (req_addr),
    .size  (req_size),
    .legal (legal)
  );

  dqspi_seq #(.TURN_BEATS(TURN_BEATS), .BEAT_W(BEAT_W)) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .wr        (req_write),
    .data_last (data_last),
    .cs_n      (spi_cs_n),
    .sclk      (spi_sclk),
    .oe        (spi_oe),
    .ready     (req_ready),
    .done      (seq_done),
    .seg       (seg),
    .beat      (beat),
    .adv       (adv),
    .sample    (sample)
  );

  dqspi_dpath #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) i_dpath (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .wr     (req_write),
    .single (req_size == 2'd0),
    .addr   (req_addr),
    .wdata  (req_wdata),
    .seg    (seg),
    .beat   (beat),
    .adv    (adv),
    .sample (sample),
    .din    (spi_din),
    .dout   (spi_dout),
    .rdata  (rsp_rdata)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= accept && !legal;
  end

  assign rsp_err  = err_q;
  assign rsp_done = seq_done | err_q;

endmodule

// File: rtl/dqspi_ctrl_chk.sv
module dqspi_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic rsp_done,
  input logic rsp_err,
  input logic spi_cs_n,
  input logic spi_sclk,
  input logic spi_oe
);

  // R3: one high cycle per beat
  a_r3_sclk_half: assert property (@(posedge clk) disable iff (!rst_n)
    (!spi_cs_n && spi_sclk) |=> !spi_sclk);

  // R3: no serial clock outside chip select
  a_r3_sclk_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  // R7: bus driven only inside an access
  a_r7_oe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
    spi_oe |-> !spi_cs_n);

  // R9: busy while selected
  a_r9_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> !req_ready);

  // R9: single-cycle strobe
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R9: good completion coincides with chip select release
  a_r9_done_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_done && !rsp_err) |-> $rose(spi_cs_n));

  // R10: refusal carries the strobe and never selects the devices
  a_r10_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_done && spi_cs_n && $past(spi_cs_n)));

endmodule

bind dqspi_ctrl dqspi_ctrl_chk i_dqspi_ctrl_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_done  (rsp_done),
  .rsp_err   (rsp_err),
  .spi_cs_n  (spi_cs_n),
  .spi_sclk  (spi_sclk),
  .spi_oe    (spi_oe)
);

// File: tb/test_dqspi_ctrl.sv
module test_dqspi_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [1:0]  req_size = 2'd0;
  logic [23:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_done;
  logic        rsp_err;
  logic [31:0] rsp_rdata;
  logic        spi_cs_n;
  logic        spi_sclk;
  logic        spi_oe;
  logic [7:0]  spi_dout;
  logic [7:0]  spi_din = 8'hEE;

  int nchk = 0;
  int nerr = 0;

  always #10 clk = ~clk;

  dqspi_ctrl i_dqspi_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_oe(spi_oe),
    .spi_dout(spi_dout), .spi_din(spi_din)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare every pin of one cycle against the model
  task automatic cyc(input string tag, input bit ecs, input bit eclk, input bit eoe,
                     input logic [7:0] eout, input bit edone, input bit eerr, input bit erdy);
    chk({tag, " cs_n"},  32'(spi_cs_n),  32'(ecs));
    chk("R3 sclk",       32'(spi_sclk),  32'(eclk));
    chk({tag, " oe"},    32'(spi_oe),    32'(eoe));
    if (eoe) chk({tag, " dout"}, 32'(spi_dout), 32'(eout));
    chk("R9 done",       32'(rsp_done),  32'(edone));
    chk({tag, " err"},   32'(rsp_err),   32'(eerr));
    chk("R9 ready",      32'(req_ready), 32'(erdy));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      cyc("R9 idle", 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
      @(negedge clk);
    end
  endtask

  // called at a falling edge; drives a request and follows it cycle by cycle
  task automatic access(input bit wr, input logic [1:0] size, input logic [23:0] addr,
                        input logic [31:0] wdata, input logic [31:0] rsrc);
    int nb;
    int nbeat;
    bit ok;
    logic [7:0]  eo[16];
    bit          eoe[16];
    logic [7:0]  di[16];
    string       tg[16];
    logic [31:0] hw;
    logic [31:0] erd;
    nb = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : (size == 2'd2) ? 4 : 0;
    ok = (nb != 0) && ((int'(addr & 24'h03FFFF) + nb) <= 32'h40000);
    req_valid = 1'b1; req_write = wr; req_size = size; req_addr = addr; req_wdata = wdata;
    @(negedge clk);
    req_valid = 1'b0;
    if (!ok) begin
      cyc(size == 2'd3 ? "R11" : "R10", 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b1);
      @(negedge clk);
      cyc(size == 2'd3 ? "R11" : "R10", 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
      return;
    end
    hw = {wr ? 8'h02 : 8'h03, addr};
    nbeat = 0;
    for (int k = 0; k < 8; k++) begin
      eo[nbeat] = {hw[31-4*k -: 4], hw[31-4*k -: 4]};
      eoe[nbeat] = 1'b1; di[nbeat] = 8'hEE; tg[nbeat] = "R4"; nbeat++;
    end
    if (!wr) begin
      for (int k = 0; k < 2; k++) begin
        eo[nbeat] = 8'h00; eoe[nbeat] = 1'b0; di[nbeat] = 8'hEE; tg[nbeat] = "R7"; nbeat++;
      end
    end
    for (int j = 0; j < ((nb == 4) ? 4 : 2); j++) begin
      eo[nbeat]  = (nb == 1) ? wdata[7:0] : wdata[8*j +: 8];
      eoe[nbeat] = wr;
      di[nbeat]  = rsrc[8*j +: 8];
      tg[nbeat]  = wr ? ((nb == 1) ? "R6" : "R5") : "R7";
      nbeat++;
    end
    for (int t = 0; t < 2*nbeat; t++) begin
      spi_din = di[t/2];
      cyc(tg[t/2], 1'b0, 1'(t % 2), eoe[t/2], eo[t/2], 1'b0, 1'b0, 1'b0);
      @(negedge clk);
    end
    spi_din = 8'hEE;
    cyc("R9 end", 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1);
    if (!wr) begin
      erd = (nb == 1) ? {24'h0, rsrc[7:0]} : (nb == 2) ? {16'h0, rsrc[15:0]} : rsrc;
      chk("R8 rdata", rsp_rdata, erd);
    end
  endtask

  initial begin
    #(20 * 100000);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      cyc("R1 reset", 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
    end
    rst_n = 1'b1;
    @(negedge clk);
    for (int t = 0; t < 16; t++) begin
      cyc("R2 boot", 1'b0, 1'(t % 2), 1'b1, ((8'h38 >> (7 - t/2)) & 8'h01) != 0 ? 8'h11 : 8'h00,
          1'b0, 1'b0, 1'b0);
      @(negedge clk);
    end
    cyc("R2 boot end", 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    idle(2);
    access(1'b1, 2'd2, 24'h000100, 32'hDEADBEEF, 32'h0);          // R5 long write
    @(negedge clk); idle(1);
    access(1'b0, 2'd2, 24'h000100, 32'h0, 32'hDEADBEEF);          // R8 long read
    access(1'b1, 2'd1, 24'h012346, 32'h1234CAFE, 32'h0);          // R12 back-to-back, R5 word
    @(negedge clk);
    access(1'b0, 2'd1, 24'h012346, 32'h0, 32'h5555A1B2);          // R8 word read
    @(negedge clk);
    access(1'b1, 2'd0, 24'h03FFFF, 32'h998877A5, 32'h0);          // R6 last byte of die
    @(negedge clk);
    access(1'b0, 2'd0, 24'h03FFFF, 32'h0, 32'h000077C3);          // R8 pad beat ignored
    @(negedge clk);
    access(1'b1, 2'd2, 24'h03FFFE, 32'h11111111, 32'h0);          // R10 crosses
    @(negedge clk);
    access(1'b0, 2'd2, 24'h07FFFC, 32'h0, 32'h01020304);          // R10 fits exactly
    @(negedge clk);
    access(1'b0, 2'd1, 24'h0BFFFF, 32'h0, 32'h0);                 // R10 word crosses
    @(negedge clk);
    access(1'b1, 2'd3, 24'h000010, 32'h0, 32'h0);                 // R11 bad size
    @(negedge clk);
    idle(3);
    access(1'b0, 2'd1, 24'h000200, 32'h0, 32'h0000BEEF);          // R12 same size held
    access(1'b0, 2'd1, 24'h000202, 32'h0, 32'h0000DEAD);
    @(negedge clk);
    idle(2);
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule